// File: doc/BRIEF.md
# Memory Ordering Issue Tracker

This block keeps track of memory operations that are in flight in an out-of-order core. It holds two small tables: one for operations that read memory and one for operations that write memory. Each operation carries a 16-bit sequence number that grows by one per operation and wraps around at the top. A reserve port places an operation into the tables it needs, or reports a stall when a needed table has reached its limit. A completion port removes an operation by its sequence number.

A combinational query port takes a sequence number and reports whether that operation may issue now. The answer follows a fixed weak-ordering rule set:

- Writes stay in order with respect to all older memory operations.
- Reads may overtake older reads.
- Reads may overtake older plain writes only when the no-alias configuration bit is set.
- Operations flagged as having side effects act as barriers. A barrier takes one slot in each table it enters. It becomes issuable only when nothing older remains in those tables.

Each table has a programmable occupancy limit. An empty flag and a full flag are exported for each table.

Top module: `memorder_tracker`

## Requirements
- R1: A plain write (in the write table, not a barrier) is not ready while any older entry is in the write table, whether that entry is a plain write or a barrier.
- R2: A plain write is not ready while any older entry is in the read table. This holds whatever the value of `cfg_no_alias`.
- R3: A plain read is ready even when older plain reads are still in the read table.
- R4: When `cfg_no_alias` is 0, a plain read is not ready while an older plain write is in the write table. When it is 1, older plain writes do not hold the read back.
- R5: A reserve with `rsv_side_fx`=1 records a barrier. With `rsv_may_load`=1 it takes one read-table slot. With `rsv_may_store`=1 it takes one write-table slot. With both set, it takes one slot in each table.
- R6: A barrier is ready only when no older entry exists in any table it occupies. A plain read waits for every older read-table barrier. A plain write waits for every older write-table barrier.
- R7: A table's full flag is 1 when its occupancy reaches the effective limit. The effective limit is the configured limit, except that a limit of 0 or a limit above the 16-entry physical depth uses 16.
- R8: `rsv_ok` is 0 and `rsv_stall` is 1 when a table the operation needs is full. An operation that both reads and writes needs room in both tables. An accepted operation occupies its slots from the next clock edge.
- R9: The empty flags are 1 when a table has no entries. A completion with `exe_valid`=1 removes every entry whose sequence number matches `exe_idx`, in both tables, at the next clock edge.
- R10: Age uses wrap-around order. Entry a is older than b when (a − b) mod 2^16, read as a signed 16-bit value, is negative. So 0xFFFE is older than 0x0001.
- R11: `qry_ready` is 0 for a sequence number that is in neither table.
- R12: A reserve with `rsv_may_load`=0 and `rsv_may_store`=0 is accepted (`rsv_ok`=1) and occupies no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_alias | input | 1 | 1: reads may overtake older plain writes |
| cfg_lq_limit | input | 5 | Read-table occupancy limit (0 or >16 means 16) |
| cfg_sq_limit | input | 5 | Write-table occupancy limit (0 or >16 means 16) |
| rsv_valid | input | 1 | Reserve request |
| rsv_idx | input | 16 | Sequence number of the reserving operation |
| rsv_may_load | input | 1 | Operation reads memory |
| rsv_may_store | input | 1 | Operation writes memory |
| rsv_side_fx | input | 1 | Operation has side effects (barrier) |
| rsv_ok | output | 1 | Reserve accepted |
| rsv_stall | output | 1 | Reserve refused: a needed table is full |
| qry_idx | input | 16 | Sequence number being queried |
| qry_ready | output | 1 | Queried operation may issue |
| exe_valid | input | 1 | Completion strobe |
| exe_idx | input | 16 | Sequence number of the completed operation |
| lq_empty | output | 1 | Read table empty |
| sq_empty | output | 1 | Write table empty |
| lq_full | output | 1 | Read table at its effective limit |
| sq_full | output | 1 | Write table at its effective limit |

## Verification
The assertions assume the following about the inputs:
- Sequence numbers in flight are unique and lie within half the index space of each other, so wrap-around age is well defined.
- A completion never names an operation reserved in the same cycle.
- The occupancy limits change only while no reserve or completion is in progress.

The stimulus keeps to these rules:
- It issues each sequence number once and completes it before reuse.
- It drives a reserve and a completion in separate cycles.
- It changes the limits only between operations.
- It includes a pair of numbers that straddle the wrap point.

// File: rtl/mo_pkg.sv
package mo_pkg;
    parameter int unsigned SEQ_W = 16;
    typedef logic [SEQ_W-1:0] seq_t;

    // Per-table summary relative to the queried sequence number
    typedef struct packed {
        logic hit;        // queried op present
        logic hit_bar;    // queried op present as a barrier
        logic old_any;    // some older entry present
        logic old_bar;    // some older barrier present
        logic old_plain;  // some older non-barrier present
    } qview_t;

    // Wrap-around age: a older than b when (a-b) is negative as signed
    function automatic logic seq_older(input seq_t a, input seq_t b);
        seq_t d;
        d = a - b;
        return d[SEQ_W-1];
    endfunction
endpackage

// File: rtl/mo_queue.sv
module mo_queue
    import mo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LIM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  seq_t             alloc_idx,
    input  logic             alloc_bar,
    input  logic             free,
    input  seq_t             free_idx,
    input  seq_t             qry_idx,
    input  logic [LIM_W-1:0] limit,
    output logic             full,
    output logic             empty,
    output qview_t           view
);
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
    localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  bar_q;
    seq_t              idx_q [DEPTH];
    logic [SLOT_W-1:0] slot;
    logic              have_slot;
    logic [CNT_W-1:0]  count;
    logic [LIM_W-1:0]  lim_cap;
    logic [DEPTH-1:0]  match_v;
    logic [DEPTH-1:0]  older_v;

    // lowest free slot
    always_comb begin
        slot      = '0;
        have_slot = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                slot      = SLOT_W'(i);
                have_slot = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            bar_q   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (free && valid_q[i] && idx_q[i] == free_idx)
                    valid_q[i] <= 1'b0;
                if (alloc && have_slot && slot == SLOT_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    bar_q[i]   <= alloc_bar;
                end
            end
        end
    end

    // index storage needs no reset: qualified by valid_q
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc && have_slot && slot == SLOT_W'(i))
                idx_q[i] <= alloc_idx;
        end
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < DEPTH; i++)
            count = count + CNT_W'(valid_q[i]);
    end

    always_comb begin
        if (limit == '0 || limit > LIM_W'(DEPTH))
            lim_cap = LIM_W'(DEPTH);
        else
            lim_cap = limit;
    end

    assign full  = (LIM_W'(count) >= lim_cap);
    assign empty = (valid_q == '0);

    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        assign match_v[g] = valid_q[g] && (idx_q[g] == qry_idx);
        assign older_v[g] = valid_q[g] && seq_older(idx_q[g], qry_idx);
    end

    assign view.hit       = |match_v;
    assign view.hit_bar   = |(match_v & bar_q);
    assign view.old_any   = |older_v;
    assign view.old_bar   = |(older_v & bar_q);
    assign view.old_plain = |(older_v & ~bar_q);
endmodule

// File: rtl/mo_rules.sv
module mo_rules
    import mo_pkg::*;
(
    input  qview_t lq,
    input  qview_t sq,
    input  logic   no_alias,
    output logic   ready
);
    logic lq_ok;
    logic sq_ok;

    always_comb begin
        if (!lq.hit)
            lq_ok = 1'b1;
        else if (lq.hit_bar)
            lq_ok = !lq.old_any;
        else
            lq_ok = !lq.old_bar && (no_alias || !sq.old_plain);
    end

    always_comb begin
        if (!sq.hit)
            sq_ok = 1'b1;
        else if (sq.hit_bar)
            sq_ok = !sq.old_any;
        else
            sq_ok = !sq.old_any && !lq.old_any;
    end

    assign ready = (lq.hit || sq.hit) && lq_ok && sq_ok;
endmodule

// File: rtl/memorder_tracker.sv
module memorder_tracker
    import mo_pkg::*;
#(
    parameter int unsigned LQ_DEPTH = 16,
    parameter int unsigned SQ_DEPTH = 16,
    parameter int unsigned LIM_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_no_alias,
    input  logic [LIM_W-1:0] cfg_lq_limit,
    input  logic [LIM_W-1:0] cfg_sq_limit,
    input  logic             rsv_valid,
    input  logic [15:0]      rsv_idx,
    input  logic             rsv_may_load,
    input  logic             rsv_may_store,
    input  logic             rsv_side_fx,
    output logic             rsv_ok,
    output logic             rsv_stall,
    input  logic [15:0]      qry_idx,
    output logic             qry_ready,
    input  logic             exe_valid,
    input  logic [15:0]      exe_idx,
    output logic             lq_empty,
    output logic             sq_empty,
    output logic             lq_full,
    output logic             sq_full
);
    qview_t lq_view;
    qview_t sq_view;
    logic   lq_block;
    logic   sq_block;

    assign lq_block  = rsv_may_load  && lq_full;
    assign sq_block  = rsv_may_store && sq_full;
    assign rsv_ok    = rsv_valid && !lq_block && !sq_block;
    assign rsv_stall = rsv_valid && (lq_block || sq_block);

    mo_queue #(.DEPTH(LQ_DEPTH), .LIM_W(LIM_W)) u_lq (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (rsv_ok && rsv_may_load),
        .alloc_idx (rsv_idx),
        .alloc_bar (rsv_side_fx),
        .free      (exe_valid),
        .free_idx  (exe_idx),
        .qry_idx   (qry_idx),
        .limit     (cfg_lq_limit),
        .full      (lq_full),
        .empty     (lq_empty),
        .view      (lq_view)
    );

    mo_queue #(.DEPTH(SQ_DEPTH), .LIM_W(LIM_W)) u_sq (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (rsv_ok && rsv_may_store),
        .alloc_idx (rsv_idx),
        .alloc_bar (rsv_side_fx),
        .free      (exe_valid),
        .free_idx  (exe_idx),
        .qry_idx   (qry_idx),
        .limit     (cfg_sq_limit),
        .full      (sq_full),
        .empty     (sq_empty),
        .view      (sq_view)
    );

    mo_rules u_rules (
        .lq       (lq_view),
        .sq       (sq_view),
        .no_alias (cfg_no_alias),
        .ready    (qry_ready)
    );
endmodule

// File: rtl/mo_checker.sv
module mo_checker #(
    parameter int unsigned LIM_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LIM_W-1:0] cfg_lq_limit,
    input logic             rsv_valid,
    input logic             rsv_may_load,
    input logic             rsv_may_store,
    input logic             rsv_ok,
    input logic             rsv_stall,
    input logic             qry_ready,
    input logic             exe_valid,
    input logic             lq_empty,
    input logic             sq_empty,
    input logic             lq_full,
    input logic             sq_full
);
    AST_STALL_LQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_valid && rsv_may_load && lq_full |-> rsv_stall && !rsv_ok); // R8
    AST_STALL_SQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_valid && rsv_may_store && sq_full |-> rsv_stall && !rsv_ok); // R8
    AST_LQ_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_ok && rsv_may_load |=> !lq_empty); // R9
    AST_LQ_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lq_empty && !(rsv_ok && rsv_may_load) |=> lq_empty); // R9
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lq_full) && !$past(exe_valid) && $stable(cfg_lq_limit) |-> lq_full); // R7
    AST_NO_FULL_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        lq_empty |-> !lq_full); // R7
    AST_READY_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        qry_ready |-> !(lq_empty && sq_empty)); // R11
endmodule

bind memorder_tracker mo_checker #(.LIM_W(LIM_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_lq_limit  (cfg_lq_limit),
    .rsv_valid     (rsv_valid),
    .rsv_may_load  (rsv_may_load),
    .rsv_may_store (rsv_may_store),
    .rsv_ok        (rsv_ok),
    .rsv_stall     (rsv_stall),
    .qry_ready     (qry_ready),
    .exe_valid     (exe_valid),
    .lq_empty      (lq_empty),
    .sq_empty      (sq_empty),
    .lq_full       (lq_full),
    .sq_full       (sq_full)
);

// File: tb/memorder_tracker_bench.sv
module memorder_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_no_alias = 1'b0;
    logic [4:0]  cfg_lq_limit = '0;
    logic [4:0]  cfg_sq_limit = '0;
    logic        rsv_valid = 1'b0;
    logic [15:0] rsv_idx = '0;
    logic        rsv_may_load = 1'b0;
    logic        rsv_may_store = 1'b0;
    logic        rsv_side_fx = 1'b0;
    logic        rsv_ok;
    logic        rsv_stall;
    logic [15:0] qry_idx = '0;
    logic        qry_ready;
    logic        exe_valid = 1'b0;
    logic [15:0] exe_idx = '0;
    logic        lq_empty;
    logic        sq_empty;
    logic        lq_full;
    logic        sq_full;

    always #4 clk = ~clk;

    memorder_tracker u_memorder_tracker (.*);

    typedef struct {
        int    kind;   // 0 ready,1 rsv_ok,2 lq_empty,3 sq_empty,4 lq_full,5 sq_full
        logic  val;
        string req;
    } item_t;

    item_t exp_q[$];
    event  sample_ev;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    // monitor: pops expectations and compares against the outputs
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                logic  act;
                it = exp_q.pop_front();
                case (it.kind)
                    0: act = qry_ready;
                    1: act = rsv_ok;
                    2: act = lq_empty;
                    3: act = sq_empty;
                    4: act = lq_full;
                    default: act = sq_full;
                endcase
                total++;
                if (act !== it.val) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%b expected=%b", it.req, it.kind, act, it.val);
                end
            end
        end
    end

    task automatic push(input int kind, input logic val, input string req);
        item_t it;
        it.kind = kind; it.val = val; it.req = req;
        exp_q.push_back(it);
        -> sample_ev;
        #2;
    endtask

    task automatic do_rsv(input logic [15:0] idx, input logic ld, input logic st,
                          input logic fx, input logic exp_ok, input string req);
        @(negedge clk);
        rsv_valid = 1'b1; rsv_idx = idx;
        rsv_may_load = ld; rsv_may_store = st; rsv_side_fx = fx;
        push(1, exp_ok, req);
        @(posedge clk);
        #1 rsv_valid = 1'b0;
    endtask

    task automatic do_exe(input logic [15:0] idx);
        @(negedge clk);
        exe_valid = 1'b1; exe_idx = idx;
        @(posedge clk);
        #1 exe_valid = 1'b0;
    endtask

    task automatic chk_q(input logic [15:0] idx, input logic exp, input string req);
        @(negedge clk);
        qry_idx = idx;
        push(0, exp, req);
    endtask

    task automatic chk(input int kind, input logic exp, input string req);
        @(negedge clk);
        push(kind, exp, req);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk(2, 1, "R9 reset lq_empty");
        chk(3, 1, "R9 reset sq_empty");
        chk(4, 0, "R7 reset lq_full");
        chk(5, 0, "R7 reset sq_full");

        // load / store / load
        do_rsv(10, 1, 0, 0, 1, "R8");
        do_rsv(11, 0, 1, 0, 1, "R8");
        do_rsv(12, 1, 0, 0, 1, "R8");
        chk_q(12, 0, "R4 load waits older store, alias on");
        cfg_no_alias = 1'b1;
        chk_q(12, 1, "R4 load passes store in no-alias mode");
        chk_q(10, 1, "R3 oldest load");
        chk_q(11, 0, "R2 store waits older load in no-alias mode");
        chk_q(99, 0, "R11 unknown index");
        do_exe(10);
        chk_q(11, 1, "R2 store free after older load done");
        cfg_no_alias = 1'b0;
        chk_q(12, 0, "R4 load waits older store again");
        do_exe(11);
        chk_q(12, 1, "R4 load free after store done");
        do_rsv(13, 1, 0, 0, 1, "R8");
        chk_q(13, 1, "R3 load passes older pending load");
        do_rsv(14, 0, 1, 0, 1, "R8");
        chk_q(14, 0, "R2 store waits older loads");
        do_exe(12);
        do_exe(13);
        chk_q(14, 1, "R2 store free");
        do_rsv(15, 0, 1, 0, 1, "R8");
        chk_q(15, 0, "R1 store waits older store");
        do_exe(14);
        chk_q(15, 1, "R1 store free after older store");
        do_exe(15);
        chk(2, 1, "R9 lq empty after completions");
        chk(3, 1, "R9 sq empty after completions");

        // load barrier
        do_rsv(20, 1, 0, 0, 1, "R8");
        do_rsv(21, 1, 0, 1, 1, "R5");
        do_rsv(22, 1, 0, 0, 1, "R8");
        chk(3, 1, "R5 load barrier stays out of write table");
        chk_q(21, 0, "R6 load barrier waits older load");
        chk_q(22, 0, "R6 load waits older load barrier");
        do_exe(20);
        chk_q(21, 1, "R6 load barrier oldest");
        chk_q(22, 0, "R6 load still behind barrier");
        do_exe(21);
        chk_q(22, 1, "R6 load free after barrier");
        do_exe(22);

        // store barrier
        cfg_no_alias = 1'b1;
        do_rsv(30, 0, 1, 0, 1, "R8");
        do_rsv(31, 0, 1, 1, 1, "R5");
        do_rsv(32, 1, 0, 0, 1, "R8");
        do_rsv(33, 0, 1, 0, 1, "R8");
        chk(2, 0, "R5 load present");
        chk_q(31, 0, "R6 store barrier waits older store");
        chk_q(32, 1, "R6 load not held by store barrier");
        do_exe(30);
        chk_q(31, 1, "R6 store barrier oldest");
        do_exe(32);
        chk_q(33, 0, "R1 store waits older store barrier");
        do_exe(31);
        chk_q(33, 1, "R1 store free after barrier");
        do_exe(33);
        cfg_no_alias = 1'b0;

        // full barrier
        do_rsv(40, 1, 1, 1, 1, "R5");
        chk(2, 0, "R5 full barrier in read table");
        chk(3, 0, "R5 full barrier in write table");
        chk_q(40, 1, "R6 lone full barrier ready");
        do_exe(40);
        chk(2, 1, "R9 full barrier removed from read table");
        chk(3, 1, "R9 full barrier removed from write table");

        // wrap-around age
        do_rsv(16'hFFFE, 0, 1, 0, 1, "R8");
        do_rsv(16'h0001, 0, 1, 0, 1, "R8");
        chk_q(16'h0001, 0, "R10 0x0001 younger than 0xFFFE");
        chk_q(16'hFFFE, 1, "R10 0xFFFE oldest");
        do_exe(16'hFFFE);
        do_exe(16'h0001);

        // neither load nor store
        do_rsv(50, 0, 0, 0, 1, "R12 accepted");
        chk(2, 1, "R12 no read slot used");
        chk(3, 1, "R12 no write slot used");

        // limits
        cfg_lq_limit = 5'd2;
        do_rsv(60, 1, 0, 0, 1, "R8");
        chk(4, 0, "R7 one below limit");
        do_rsv(61, 1, 0, 0, 1, "R8");
        chk(4, 1, "R7 full at limit 2");
        do_rsv(62, 1, 0, 0, 0, "R8 load stalls on full");
        do_rsv(63, 0, 1, 0, 1, "R8 store unaffected");
        do_rsv(64, 1, 1, 0, 0, "R8 load-store needs both tables");
        chk_q(62, 0, "R8 stalled op not recorded");
        cfg_lq_limit = 5'd0;
        chk(4, 0, "R7 limit 0 uses full depth");
        do_exe(60);
        do_exe(61);
        do_exe(63);

        cfg_lq_limit = 5'd20;
        for (int k = 0; k < 16; k++) begin
            do_rsv(16'(70 + k), 1, 0, 0, 1, "R7 fill");
        end
        chk(4, 1, "R7 limit above depth caps at 16");
        do_rsv(86, 1, 0, 0, 0, "R8 stall at physical depth");
        for (int k = 0; k < 16; k++) begin
            do_exe(16'(70 + k));
        end
        chk(2, 1, "R9 empty after draining");
        chk(4, 0, "R7 not full after draining");

        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule